// File: doc/BRIEF.md
# Register Memory Slave with Kernel Run Control

This block is a memory-mapped slave with a 32-bit byte address and a 64-bit data path. It follows the single-transfer rules of AXI4-Lite, and it also accepts incrementing bursts. Behind the bus is a small word-addressed store of five 64-bit words. Words 0 to 3 hold packed fields that an attached compute kernel reads and writes. Word 4 is a one-bit run-control and status word. A write to word 4 launches the kernel. A read of word 4 reports whether the last run has completed.

The kernel is a fixed-latency stub. When it starts, it captures its inputs: eight byte fields and two 32-bit operands. After `KERNEL_CYCLES` cycles it writes back three results: a 64-bit sum, an exclusive-or and an inclusive-or. A parameter sets the policy for bus access while the kernel runs. In one policy the data words are fenced off from the bus until the run ends. In the other, the bus and the kernel share the store, and the kernel gives way to bus writes when both want the store in the same cycle.

Top module: `regmem_axil_run`

## Requirements
- R1: After reset, `s_awready` and `s_arready` are 1, `s_bvalid`, `s_rvalid` and `run_kick` are 0, every data word reads as zero, and word 4 reads as 0.
- R2: The word index is the byte address divided by 8, and address bits [2:0] are ignored. Word 0 holds byte field i in bits [8i+7:8i]. Word 1 holds operand a in [31:0] and operand b in [63:32]. Word 2 holds the sum. Word 3 holds the exclusive-or in [31:0] and the inclusive-or in [63:32]. Written lanes read back unchanged.
- R3: Fields are 1 byte wide in word 0, 4 bytes wide in words 1 and 3, and 8 bytes wide in word 2. The strobe bits over one field must be all set or all clear. A field whose strobe is only partly set is left unchanged, and the burst answers SLVERR (`2'b10`). Fully strobed fields in the same beat are still written. A burst with no such fault answers OKAY (`2'b00`).
- R4: A beat whose word index is above 4 changes nothing and makes the response SLVERR. A read beat at such an index returns zero data with SLVERR.
- R5: A write beat to word 4 while the kernel is idle starts a run, whatever its strobe. It produces a one-cycle `run_kick` pulse in the following cycle and clears the completion bit. Word 4 reads back the completion bit in bit 0, with zeros above it, and always answers OKAY.
- R6: A write to word 4 while a run is in progress is ignored: no `run_kick` pulse, no restart, and the response is OKAY.
- R7: The kernel captures words 0 and 1 when a run starts. `KERNEL_CYCLES` cycles later (or later, under R10) it writes word 2 = a + b + the sum of the eight byte fields, and word 3 = {a | b, a ^ b}. In the same cycle it sets the completion bit.
- R8: A burst of `len`+1 beats uses word index start+k on beat k. On reads, `s_rlast` is set on beat `len` only. A write burst ends after `len`+1 data beats, and its response is SLVERR if any beat faulted.
- R9: With `CONCURRENT` = 0, while a run is in progress, bus beats to words 0 to 3 answer SLVERR. Writes are dropped and reads return zero. Word 4 stays accessible.
- R10: With `CONCURRENT` = 1, bus beats to words 0 to 3 proceed normally during a run. A bus write landing in the kernel's write-back cycle postpones the write-back and the completion bit by one cycle.
- R11: Once `s_bvalid` or `s_rvalid` is raised, it stays high, with the response, data and last flag unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 32 | Write burst start byte address |
| s_awlen | input | 8 | Write burst beats minus one |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 64 | Write data |
| s_wstrb | input | 8 | Write byte strobes |
| s_wlast | input | 1 | Last write beat flag (not used; beat count governs) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write burst response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 32 | Read burst start byte address |
| s_arlen | input | 8 | Read burst beats minus one |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 64 | Read data |
| s_rresp | output | 2 | Read beat response |
| s_rlast | output | 1 | Final read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| run_kick | output | 1 | One-cycle pulse when a kernel run begins |

## Verification
The bench builds two copies side by side on one shared bus: one with `CONCURRENT` = 0 and one with `CONCURRENT` = 1, both with `KERNEL_CYCLES` = 40. A single stimulus stream therefore shows a fenced access and a shared access to the same word in the same cycle. The long run window leaves room for several full bus transactions while the kernel is busy. In that window the bench can read results before they are ready, rewrite the operands after they have been captured, and issue a second start, all before completion is polled.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 64;
  localparam int LANES      = DATA_W / 8;
  localparam int WORD_SHIFT = $clog2(LANES);
  localparam int IDX_W      = ADDR_W - WORD_SHIFT;
  localparam int DATA_WORDS = 4;

  localparam logic [IDX_W-1:0] CTRL_AT = IDX_W'(DATA_WORDS);

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  // Field width in byte lanes for each data word of the packed layout.
  function automatic int field_span(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0):            return 1;
      IDX_W'(1), IDX_W'(3): return 4;
      default:              return LANES;
    endcase
  endfunction

  // Lanes that may be written: set in strb and part of a fully strobed field.
  function automatic logic [LANES-1:0] whole_lanes(input logic [IDX_W-1:0] idx,
                                                   input logic [LANES-1:0] strb);
    int span;
    logic full;
    logic [LANES-1:0] keep;
    span = field_span(idx);
    keep = '0;
    for (int l = 0; l < LANES; l++) begin
      full = 1'b1;
      for (int k = 0; k < LANES; k++) begin
        if ((k / span) == (l / span) && !strb[k]) full = 1'b0;
      end
      keep[l] = strb[l] && full;
    end
    return keep;
  endfunction
endpackage

// File: rtl/regmem_wr_ch.sv
module regmem_wr_ch
  import regmem_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter bit CONCURRENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic              awvalid,
  output logic              awready,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wlast,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic              kern_busy,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [LANES-1:0]  wr_lanes,
  output logic              start_req
);
  typedef enum logic [1:0] {WS_ADDR, WS_DATA, WS_RESP} wstate_e;

  wstate_e          state;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] beats_left;
  logic             err;
  logic             beat;
  logic             fenced;
  logic [LANES-1:0] keep;
  logic             beat_err;
  logic             unused_bits;

  assign unused_bits = ^{awaddr[WORD_SHIFT-1:0], wlast};

  assign beat     = (state == WS_DATA) && wvalid;
  assign fenced   = !CONCURRENT && kern_busy;
  assign keep     = whole_lanes(idx, wstrb);
  assign beat_err = (idx > CTRL_AT) ||
                    ((idx < CTRL_AT) && (fenced || ((wstrb & ~keep) != '0)));

  assign wr_idx    = idx;
  assign wr_lanes  = (beat && (idx < CTRL_AT) && !fenced) ? keep : '0;
  assign start_req = beat && (idx == CTRL_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_ADDR;
      idx        <= '0;
      beats_left <= '0;
      err        <= 1'b0;
    end else begin
      case (state)
        WS_ADDR: if (awvalid) begin
          idx        <= awaddr[ADDR_W-1:WORD_SHIFT];
          beats_left <= awlen;
          err        <= 1'b0;
          state      <= WS_DATA;
        end
        WS_DATA: if (wvalid) begin
          err        <= err | beat_err;
          idx        <= idx + 1'b1;
          beats_left <= beats_left - 1'b1;
          if (beats_left == '0) state <= WS_RESP;
        end
        default: if (bready) state <= WS_ADDR;
      endcase
    end
  end

  assign awready = (state == WS_ADDR);
  assign wready  = (state == WS_DATA);
  assign bvalid  = (state == WS_RESP);
  assign bresp   = err ? RESP_SLVERR : RESP_OKAY;

  assert_bresp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  assert_bresp_code_R3: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> (bresp == RESP_OKAY || bresp == RESP_SLVERR));
endmodule

// File: rtl/regmem_rd_ch.sv
module regmem_rd_ch
  import regmem_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter bit CONCURRENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [LEN_W-1:0]  arlen,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              rvalid,
  input  logic              rready,
  input  logic              kern_busy,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_raw
);
  typedef enum logic {RS_ADDR, RS_DATA} rstate_e;

  rstate_e          state;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] beats_left;
  logic             fetch_ok;
  logic             unused_bits;

  assign unused_bits = ^araddr[WORD_SHIFT-1:0];

  assign rd_idx   = (state == RS_ADDR) ? araddr[ADDR_W-1:WORD_SHIFT] : idx + 1'b1;
  assign fetch_ok = (rd_idx == CTRL_AT) ||
                    ((rd_idx < CTRL_AT) && (CONCURRENT || !kern_busy));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_ADDR;
      idx        <= '0;
      beats_left <= '0;
      rdata      <= '0;
      rresp      <= RESP_OKAY;
      rlast      <= 1'b0;
    end else begin
      case (state)
        RS_ADDR: if (arvalid) begin
          idx        <= rd_idx;
          beats_left <= arlen;
          rdata      <= fetch_ok ? rd_raw : '0;
          rresp      <= fetch_ok ? RESP_OKAY : RESP_SLVERR;
          rlast      <= (arlen == '0);
          state      <= RS_DATA;
        end
        default: if (rready) begin
          if (beats_left == '0) begin
            state <= RS_ADDR;
            rlast <= 1'b0;
          end else begin
            idx        <= rd_idx;
            beats_left <= beats_left - 1'b1;
            rdata      <= fetch_ok ? rd_raw : '0;
            rresp      <= fetch_ok ? RESP_OKAY : RESP_SLVERR;
            rlast      <= (beats_left == LEN_W'(1));
          end
        end
      endcase
    end
  end

  assign arready = (state == RS_ADDR);
  assign rvalid  = (state == RS_DATA);

  assert_rhold_R11: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp) && $stable(rlast)));

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rresp == RESP_SLVERR) |-> (rdata == '0));
endmodule

// File: rtl/regmem_kernel.sv
module regmem_kernel
  import regmem_pkg::*;
#(
  parameter int CYCLES     = 8,
  parameter bit CONCURRENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              bus_wr_any,
  input  logic [DATA_W-1:0] in_bytes,
  input  logic [DATA_W-1:0] in_ops,
  output logic              busy,
  output logic              done,
  output logic              kick,
  output logic              res_we,
  output logic [DATA_W-1:0] res_sum,
  output logic [DATA_W-1:0] res_logic
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam int HALF  = DATA_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cap_bytes;
  logic [HALF-1:0]   cap_a;
  logic [HALF-1:0]   cap_b;
  logic              start_ok;
  logic              wb_due;
  logic              wb_hold;

  assign start_ok = start_req && !busy;
  assign wb_due   = busy && (cnt == '0);
  assign wb_hold  = CONCURRENT && bus_wr_any;
  assign res_we   = wb_due && !wb_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      kick      <= 1'b0;
      cnt       <= '0;
      cap_bytes <= '0;
      cap_a     <= '0;
      cap_b     <= '0;
    end else begin
      kick <= start_ok;
      if (start_ok) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        cnt       <= CNT_W'(CYCLES - 1);
        cap_bytes <= in_bytes;
        cap_a     <= in_ops[HALF-1:0];
        cap_b     <= in_ops[DATA_W-1:HALF];
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (!wb_hold) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    res_sum = DATA_W'(cap_a) + DATA_W'(cap_b);
    for (int i = 0; i < LANES; i++) res_sum = res_sum + DATA_W'(cap_bytes[8*i +: 8]);
    res_logic = {cap_a | cap_b, cap_a ^ cap_b};
  end

  assert_kick_runs_R5: assert property (@(posedge clk) disable iff (rst)
    kick |-> (busy && !done));

  assert_end_sets_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0 && start_req) |=> (busy && !kick));

  assert_defer_R10: assert property (@(posedge clk) disable iff (rst)
    (wb_due && wb_hold) |=> busy);
endmodule

// File: rtl/regmem_axil_run.sv
module regmem_axil_run
  import regmem_pkg::*;
#(
  parameter bit CONCURRENT    = 1'b0,
  parameter int KERNEL_CYCLES = 8,
  parameter int LEN_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [LANES-1:0]  s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              run_kick
);
  localparam int SLOT_W = $clog2(DATA_WORDS);

  logic [IDX_W-1:0]  wr_idx;
  logic [LANES-1:0]  wr_lanes;
  logic              start_req;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_raw;
  logic              kern_busy;
  logic              kern_done;
  logic              res_we;
  logic [DATA_W-1:0] res_sum;
  logic [DATA_W-1:0] res_logic;
  logic [DATA_W-1:0] store [DATA_WORDS];

  regmem_wr_ch #(.LEN_W(LEN_W), .CONCURRENT(CONCURRENT)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awlen(s_awlen), .awvalid(s_awvalid), .awready(s_awready),
    .wstrb(s_wstrb), .wlast(s_wlast), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .kern_busy(kern_busy), .wr_idx(wr_idx), .wr_lanes(wr_lanes), .start_req(start_req)
  );

  regmem_rd_ch #(.LEN_W(LEN_W), .CONCURRENT(CONCURRENT)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arlen(s_arlen), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rlast(s_rlast), .rvalid(s_rvalid), .rready(s_rready),
    .kern_busy(kern_busy), .rd_idx(rd_idx), .rd_raw(rd_raw)
  );

  regmem_kernel #(.CYCLES(KERNEL_CYCLES), .CONCURRENT(CONCURRENT)) u_kern (
    .clk(clk), .rst(rst),
    .start_req(start_req), .bus_wr_any(|wr_lanes),
    .in_bytes(store[0]), .in_ops(store[1]),
    .busy(kern_busy), .done(kern_done), .kick(run_kick),
    .res_we(res_we), .res_sum(res_sum), .res_logic(res_logic)
  );

  // One always_ff per word; result words also take the kernel write-back.
  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
    logic hit;
    assign hit = (wr_idx[SLOT_W-1:0] == SLOT_W'(w));
    always_ff @(posedge clk) begin
      if (rst) begin
        store[w] <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (hit && wr_lanes[l]) store[w][8*l +: 8] <= s_wdata[8*l +: 8];
        end
        if (w == 2 && res_we) store[w] <= res_sum;
        if (w == 3 && res_we) store[w] <= res_logic;
      end
    end
  end

  always_comb begin
    rd_raw = '0;
    if (rd_idx < CTRL_AT)       rd_raw = store[rd_idx[SLOT_W-1:0]];
    else if (rd_idx == CTRL_AT) rd_raw = DATA_W'(kern_done);
  end

  assert_fence_R9: assert property (@(posedge clk) disable iff (rst)
    (!CONCURRENT && kern_busy) |-> (wr_lanes == '0));

  assert_kick_once_R5: assert property (@(posedge clk) disable iff (rst)
    run_kick |=> !run_kick);
endmodule

// File: tb/test_regmem_axil_run.sv
`timescale 1ns/1ps
module test_regmem_axil_run;
  localparam int KC = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] awaddr = '0;
  logic [7:0]  awlen = '0;
  logic        awvalid = 1'b0;
  logic [63:0] wdata = '0;
  logic [7:0]  wstrb = '0;
  logic        wlast = 1'b0;
  logic        wvalid = 1'b0;
  logic        bready = 1'b0;
  logic [31:0] araddr = '0;
  logic [7:0]  arlen = '0;
  logic        arvalid = 1'b0;
  logic        rready = 1'b0;

  logic        awready_a, wready_a, bvalid_a, arready_a, rvalid_a, rlast_a, kick_a;
  logic        awready_b, wready_b, bvalid_b, arready_b, rvalid_b, rlast_b, kick_b;
  logic [1:0]  bresp_a, bresp_b, rresp_a, rresp_b;
  logic [63:0] rdata_a, rdata_b;

  always #4 clk = ~clk;

  regmem_axil_run #(.CONCURRENT(1'b0), .KERNEL_CYCLES(KC)) i_regmem_axil_run (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awlen(awlen), .s_awvalid(awvalid), .s_awready(awready_a),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast), .s_wvalid(wvalid), .s_wready(wready_a),
    .s_bresp(bresp_a), .s_bvalid(bvalid_a), .s_bready(bready),
    .s_araddr(araddr), .s_arlen(arlen), .s_arvalid(arvalid), .s_arready(arready_a),
    .s_rdata(rdata_a), .s_rresp(rresp_a), .s_rlast(rlast_a), .s_rvalid(rvalid_a), .s_rready(rready),
    .run_kick(kick_a));

  regmem_axil_run #(.CONCURRENT(1'b1), .KERNEL_CYCLES(KC)) i_regmem_axil_run_shared (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awlen(awlen), .s_awvalid(awvalid), .s_awready(awready_b),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast), .s_wvalid(wvalid), .s_wready(wready_b),
    .s_bresp(bresp_b), .s_bvalid(bvalid_b), .s_bready(bready),
    .s_araddr(araddr), .s_arlen(arlen), .s_arvalid(arvalid), .s_arready(arready_b),
    .s_rdata(rdata_b), .s_rresp(rresp_b), .s_rlast(rlast_b), .s_rvalid(rvalid_b), .s_rready(rready),
    .run_kick(kick_b));

  int          checks = 0;
  int          fails = 0;
  int          kicks_a = 0;
  int          kicks_b = 0;
  logic [63:0] ma [4];
  logic [63:0] mb [4];
  logic        exp_done = 1'b0;
  logic [63:0] wd [16];
  logic [7:0]  ws [16];

  always @(negedge clk) begin
    if (kick_a) kicks_a++;
    if (kick_b) kicks_b++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_keep(input int idx, input logic [7:0] s);
    case (idx)
      0: return s;
      2: return (s == 8'hFF) ? 8'hFF : 8'h00;
      default: return ((s[3:0] == 4'hF) ? 8'h0F : 8'h00) | ((s[7:4] == 4'hF) ? 8'hF0 : 8'h00);
    endcase
  endfunction

  function automatic logic [63:0] f_sum(input logic [63:0] w0, input logic [63:0] w1);
    logic [63:0] t;
    t = {32'h0, w1[31:0]} + {32'h0, w1[63:32]};
    for (int i = 0; i < 8; i++) t = t + {56'h0, w0[8*i +: 8]};
    return t;
  endfunction

  function automatic logic [63:0] f_logic(input logic [63:0] w1);
    return {w1[31:0] | w1[63:32], w1[31:0] ^ w1[63:32]};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic [7:0] k);
    logic [63:0] r;
    r = old;
    for (int l = 0; l < 8; l++) if (k[l]) r[8*l +: 8] = d[8*l +: 8];
    return r;
  endfunction

  // Write burst from wd/ws; fence_a marks the fenced copy's kernel as busy.
  task automatic wr_burst(input logic [31:0] addr, input int len, input logic fence_a,
                          input int hold, input string req);
    logic ea, eb;
    logic [1:0] ra;
    int idx;
    ea = 1'b0; eb = 1'b0;
    @(negedge clk);
    awaddr = addr; awlen = 8'(len); awvalid = 1'b1;
    while (!awready_a) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      idx = int'(addr >> 3) + i;
      wdata = wd[i]; wstrb = ws[i]; wlast = (i == len); wvalid = 1'b1;
      while (!wready_a) @(negedge clk);
      if (idx > 4) begin
        ea = 1'b1; eb = 1'b1;
      end else if (idx < 4) begin
        if ((ws[i] & ~f_keep(idx, ws[i])) != 8'h00) begin
          ea = 1'b1; eb = 1'b1;
        end
        if (fence_a) ea = 1'b1;
        else ma[idx] = merge(ma[idx], wd[i], f_keep(idx, ws[i]));
        mb[idx] = merge(mb[idx], wd[i], f_keep(idx, ws[i]));
      end
      @(negedge clk);
    end
    wvalid = 1'b0; wlast = 1'b0;
    while (!bvalid_a) @(negedge clk);
    ra = bresp_a;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R11 bvalid held", {63'h0, bvalid_a}, 64'h1);
      chk("R11 bresp stable", {62'h0, bresp_a}, {62'h0, ra});
    end
    chk({req, " bresp fenced copy"}, {62'h0, bresp_a}, ea ? 64'h2 : 64'h0);
    chk({req, " bresp shared copy"}, {62'h0, bresp_b}, eb ? 64'h2 : 64'h0);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic rd_burst(input logic [31:0] addr, input int len, input logic fence_a,
                          input int hold, input string req);
    int idx;
    logic [63:0] xa, xb, ha;
    logic ba;
    @(negedge clk);
    araddr = addr; arlen = 8'(len); arvalid = 1'b1;
    while (!arready_a) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      idx = int'(addr >> 3) + i;
      while (!rvalid_a) @(negedge clk);
      ba = 1'b0;
      if (idx == 4) begin
        xa = {63'h0, exp_done}; xb = xa;
      end else if (idx < 4) begin
        xa = fence_a ? 64'h0 : ma[idx]; ba = fence_a; xb = mb[idx];
      end else begin
        xa = 64'h0; xb = 64'h0; ba = 1'b1;
      end
      chk({req, " rdata fenced copy"}, rdata_a, xa);
      chk({req, " rdata shared copy"}, rdata_b, xb);
      chk({req, " rresp fenced copy"}, {62'h0, rresp_a}, ba ? 64'h2 : 64'h0);
      chk({req, " rresp shared copy"}, {62'h0, rresp_b}, (idx > 4) ? 64'h2 : 64'h0);
      chk("R8 rlast position", {63'h0, rlast_a}, {63'h0, (i == len)});
      ha = rdata_a;
      if (hold > 0) begin
        @(negedge clk);
        chk("R11 rdata stable", rdata_a, ha);
        chk("R11 rvalid held", {63'h0, rvalid_a}, 64'h1);
      end
      rready = 1'b1;
      @(negedge clk);
      rready = 1'b0;
    end
  endtask

  task automatic poll_ctrl(output logic [63:0] da, output logic [63:0] db);
    @(negedge clk);
    araddr = 32'h20; arlen = 8'h0; arvalid = 1'b1;
    while (!arready_a) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (!rvalid_a) @(negedge clk);
    da = rdata_a; db = rdata_b;
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 handshake stalled actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb, sum_x, log_x;
    int st, ln, got;
    void'($urandom(32'd1234));
    for (int w = 0; w < 4; w++) begin ma[w] = '0; mb[w] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 awready", {63'h0, awready_a}, 64'h1);
    chk("R1 arready", {63'h0, arready_a}, 64'h1);
    chk("R1 bvalid", {63'h0, bvalid_a}, 64'h0);
    chk("R1 rvalid", {63'h0, rvalid_b}, 64'h0);
    chk("R1 run_kick", {63'h0, kick_a}, 64'h0);
    rd_burst(32'h0, 4, 1'b0, 0, "R1 words after reset");

    // R2 field layout and ignored low address bits
    wd[0] = 64'h8877_6655_4433_2211; ws[0] = 8'hFF;
    wr_burst(32'h0000_0005, 0, 1'b0, 0, "R2 word0 via offset 5");
    wd[0] = 64'h0000_0003_0000_0010; ws[0] = 8'hFF;
    wr_burst(32'h8, 0, 1'b0, 1, "R2 word1");
    rd_burst(32'hF, 0, 1'b0, 0, "R2 word1 via offset 15");

    // R3 strobe alignment
    wd[0] = 64'hAAAA_AAAA_BBBB_BBBB; ws[0] = 8'h1F;
    wr_burst(32'h8, 0, 1'b0, 2, "R3 partial b field");
    wd[0] = 64'h1234_5678_9ABC_DEF0; ws[0] = 8'h0F;
    wr_burst(32'h10, 0, 1'b0, 0, "R3 partial 64-bit field");
    wd[0] = 64'h55AA_0000_0000_00C3; ws[0] = 8'h81;
    wr_burst(32'h0, 0, 1'b0, 0, "R3 byte fields scattered");
    rd_burst(32'h0, 3, 1'b0, 1, "R3 readback");

    // R4 out-of-range words
    wd[0] = 64'hFFFF; ws[0] = 8'hFF;
    wr_burst(32'h40, 0, 1'b0, 0, "R4 write word 8");
    rd_burst(32'h28, 1, 1'b0, 0, "R4 read words 5-6");
    rd_burst(32'h8000_0000, 0, 1'b0, 0, "R4 high address");

    // R8 write burst across words, read burst spilling past the control word
    for (int i = 0; i < 4; i++) begin wd[i] = {$urandom, $urandom}; ws[i] = 8'hFF; end
    wr_burst(32'h0, 3, 1'b0, 0, "R8 write burst");
    rd_burst(32'h8, 4, 1'b0, 0, "R8 read burst spill");

    // Constrained random traffic, kernel idle
    for (int n = 0; n < 150; n++) begin
      st = int'($urandom_range(0, 3));
      ln = int'($urandom_range(0, 3 - st));
      if ($urandom_range(0, 1) == 0) begin
        for (int i = 0; i <= ln; i++) begin
          wd[i] = {$urandom, $urandom};
          ws[i] = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
        end
        wr_burst(32'(st * 8), ln, 1'b0, int'($urandom_range(0, 2)), "R3 R8 random write");
      end else begin
        rd_burst(32'(st * 8), int'($urandom_range(0, 5 - st)), 1'b0,
                 int'($urandom_range(0, 1)), "R2 R8 random read");
      end
    end

    // Kernel run: R5, R6, R7, R9, R10
    wd[0] = 64'hF0E1_D2C3_B4A5_9687; ws[0] = 8'hFF;
    wd[1] = 64'h8000_0001_FFFF_FFFF; ws[1] = 8'hFF;
    wr_burst(32'h0, 1, 1'b0, 0, "R7 load inputs");
    sum_x = f_sum(ma[0], ma[1]);
    log_x = f_logic(ma[1]);
    wd[0] = 64'h0; ws[0] = 8'h00;
    wr_burst(32'h20, 0, 1'b0, 0, "R5 start write");
    exp_done = 1'b0;
    chk("R5 kick count fenced copy", 64'(kicks_a), 64'h1);
    chk("R5 kick count shared copy", 64'(kicks_b), 64'h1);
    rd_burst(32'h20, 0, 1'b0, 0, "R5 done clear while busy");
    rd_burst(32'h10, 0, 1'b1, 0, "R9 R10 read result word while busy");
    wd[0] = 64'h0000_0007_0000_0009; ws[0] = 8'hFF;
    wr_burst(32'h8, 0, 1'b1, 0, "R9 R10 rewrite inputs while busy");
    ws[0] = 8'h01; wd[0] = 64'h1;
    wr_burst(32'h20, 0, 1'b1, 0, "R6 second start");
    chk("R6 no restart fenced copy", 64'(kicks_a), 64'h1);
    chk("R6 no restart shared copy", 64'(kicks_b), 64'h1);
    got = 0;
    for (int p = 0; p < 60 && got == 0; p++) begin
      poll_ctrl(pa, pb);
      if (pa[0]) got = 1;
    end
    chk("R7 completion seen", 64'(got), 64'h1);
    chk("R7 shared copy done", pb, 64'h1);
    exp_done = 1'b1;
    ma[2] = sum_x; ma[3] = log_x; mb[2] = sum_x; mb[3] = log_x;
    rd_burst(32'h0, 4, 1'b0, 0, "R7 R9 R10 results and inputs");
    chk("R6 kick count final", 64'(kicks_a), 64'h1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule